// File: doc/BRIEF.md
# Glitch-free clock source switcher

The block drives one domain clock from one of five free-running input clocks. Software picks the source by writing a 3-bit index into a configuration word. The word also carries unrelated upper fields and a read-only busy flag. When the index changes, the block performs a break-before-make handover. First it gates the old source off while that source is low. Only when the old gate is confirmed closed does it let the new source's gate open, again while that source is low. The busy flag stays high for the whole handover.

Index 0 is the fast system oscillator, index 1 the 32.768 kHz real-time oscillator, and indexes 2, 3 and 4 three PLL outputs. The configuration side runs on its own register clock. Each source gate is controlled by two flops in that source's clock domain. The gate state of every source is synchronised back into the register clock domain with two flops, and the block uses it as the acknowledgement of the handover.

Top module: `clk_src_switch`

## Requirements
- R1: Once busy is low, the output clock has the period of the source named by the select field. The mapping is 0 = fast oscillator, 1 = real-time oscillator, and 2 to 4 = PLL outputs on src_clk_i[2] to src_clk_i[4].
- R2: Bits [2:0] of the read word always return the most recently accepted index. This includes an index written while a handover was still running.
- R3: A write whose resulting index is 5, 6 or 7 leaves the select field, the busy flag and the output clock source unchanged.
- R4: Bit 3 of the read word is the busy flag. It is 1 from the register-clock edge that accepts a changed index. Write data on bit 3 has no effect.
- R5: Busy clears only after the newly selected source's gate is open and that source is driving the output. After reset, busy is 1 until source 0 drives the output.
- R6: Writing the index that is already selected while idle starts no handover, and busy stays 0.
- R7: A valid index written while busy is high is held. It is applied after the current handover completes, and busy stays high until the held source drives the output.
- R8: Bits [CFG_W-1:4] are plain storage. A write updates only the bits whose wr_mask_i bit is 1, and the select field merges the same way. A write that changes only [2:0] leaves the upper bits unchanged.
- R9: No source gate opens while another is acknowledged open. Every high or low phase of the output lasts at least half a period of the fastest source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | 5 | Candidate source clocks, bit n is index n |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | CFG_W | Write data |
| wr_mask_i | input | CFG_W | Per-bit write enable |
| rd_data_o | output | CFG_W | Read word: upper storage, busy at bit 3, index at [2:0] |
| busy_o | output | 1 | Handover in progress |
| clk_o | output | 1 | Selected domain clock |

## Verification
The bench builds the block with the default 32-bit word, so the full upper storage field is exercised under random masks. The five sources run at 7, 61, 13, 17 and 23 ns. Because these periods are distinct and mutually unrelated, a period measurement after each handover identifies which source is driving the output, and the gate transitions fall at varying phases. The 7 ns source sets the minimum pulse width that the runt monitor enforces on every output edge. The 61 ns source forces the handover wait to span several register cycles.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int NSRC     = 5;
  localparam int SEL_W    = 3;
  localparam int BUSY_BIT = 3;
  localparam int LOW_W    = BUSY_BIT + 1;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/clk_gate_lane.sv
module clk_gate_lane (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  logic s1_q, en_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= 1'b0;
    else         s1_q <= req_i;
  end

  // gate changes only on the falling edge, while the source is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= s1_q;
  end

  assign en_o   = en_q;
  assign gclk_o = src_clk_i & en_q;
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import clk_sw_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [CFG_W-1:0] wr_mask_i,
  input  logic [NSRC-1:0]  ack_i,
  output logic [NSRC-1:0]  req_o,
  output logic [CFG_W-1:0] rd_data_o,
  output logic             busy_o
);
  localparam int HI_W = CFG_W - LOW_W;

  logic [SEL_W-1:0] tgt_q, pend_sel_q, cur_sel, new_sel;
  logic [HI_W-1:0]  upper_q;
  logic             busy_q, pend_q, done, sel_wr, sel_ok;
  logic [NSRC-1:0]  tgt_hot;
  logic             unused_bit3;

  assign unused_bit3 = wr_data_i[BUSY_BIT] ^ wr_mask_i[BUSY_BIT];

  assign cur_sel = pend_q ? pend_sel_q : tgt_q;
  assign new_sel = (cur_sel & ~wr_mask_i[SEL_W-1:0]) | (wr_data_i[SEL_W-1:0] & wr_mask_i[SEL_W-1:0]);
  assign sel_ok  = new_sel < SEL_W'(NSRC);
  assign sel_wr  = wr_en_i && (|wr_mask_i[SEL_W-1:0]) && sel_ok;
  assign tgt_hot = NSRC'(1) << tgt_q;
  assign done    = busy_q && (ack_i == tgt_hot);
  assign busy_o  = busy_q | pend_q;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_req
      localparam logic [NSRC-1:0] OTHERS = ~(NSRC'(1) << gi);
      // break-before-make: open only once every other gate is seen closed
      assign req_o[gi] = (tgt_q == SEL_W'(gi)) && ((ack_i & OTHERS) == '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q      <= '0;
      pend_sel_q <= '0;
      pend_q     <= 1'b0;
      busy_q     <= 1'b1;
      upper_q    <= '0;
    end else begin
      if (wr_en_i)
        upper_q <= (upper_q & ~wr_mask_i[CFG_W-1:LOW_W]) | (wr_data_i[CFG_W-1:LOW_W] & wr_mask_i[CFG_W-1:LOW_W]);
      if (done) busy_q <= 1'b0;
      if (!busy_q && pend_q) begin
        pend_q <= 1'b0;
        if (pend_sel_q != tgt_q) begin
          tgt_q  <= pend_sel_q;
          busy_q <= 1'b1;
        end
      end
      if (sel_wr) begin
        if (busy_o) begin
          pend_q     <= 1'b1;
          pend_sel_q <= new_sel;
        end else if (new_sel != tgt_q) begin
          tgt_q  <= new_sel;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign rd_data_o = {upper_q, busy_o, cur_sel};

  a_r9_one_gate_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));
  a_r3_target_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_q < SEL_W'(NSRC));
  a_r3_invalid_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i && !sel_ok) |=> (!busy_o && $stable(tgt_q)));
  a_r4_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i));
  a_r5_clear_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (ack_i == tgt_hot));
  a_r6_same_no_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sel_wr && new_sel == tgt_q) |=> !busy_o);
  a_r7_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sel_wr) |=> busy_o);
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_sw_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       src_clk_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [CFG_W-1:0] wr_mask_i,
  output logic [CFG_W-1:0] rd_data_o,
  output logic             busy_o,
  output logic             clk_o
);
  logic [NSRC-1:0] req, en, ack, gclk;

  sw_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_mask_i (wr_mask_i),
    .ack_i     (ack),
    .req_o     (req),
    .rd_data_o (rd_data_o),
    .busy_o    (busy_o)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_lane
      clk_gate_lane u_lane (
        .src_clk_i (src_clk_i[gi]),
        .rst_ni    (rst_ni),
        .req_i     (req[gi]),
        .en_o      (en[gi]),
        .gclk_o    (gclk[gi])
      );
    end
  endgenerate

  bit_sync #(.W(NSRC)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en),
    .q_o    (ack)
  );

  assign clk_o = |gclk;
endmodule

// File: tb/sim_clk_src_switch.sv
`timescale 1ns/1ps
module sim_clk_src_switch;
  localparam int CFG_W = 32;
  localparam real MIN_HALF = 3.5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [4:0]       sclk = '0;
  logic             wr_en = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic [CFG_W-1:0] wr_mask = '0;
  logic [CFG_W-1:0] rd_data;
  logic             busy, clk_o;

  int total = 0;
  int bad = 0;
  int runts = 0;
  int cur = 0;
  logic [CFG_W-1:4] exp_up = '0;
  realtime t_r = 0.0, t_f = 0.0;

  always #5 clk = ~clk;
  always #3.5  sclk[0] = ~sclk[0];
  always #30.5 sclk[1] = ~sclk[1];
  always #6.5  sclk[2] = ~sclk[2];
  always #8.5  sclk[3] = ~sclk[3];
  always #11.5 sclk[4] = ~sclk[4];

  clk_src_switch #(.CFG_W(CFG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(sclk), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .rd_data_o(rd_data),
    .busy_o(busy), .clk_o(clk_o)
  );

  // R9 pulse-width monitor
  always @(posedge clk_o) begin
    if (rst_n && t_f > 0.0 && ($realtime - t_f) < MIN_HALF - 0.1) runts++;
    t_r = $realtime;
  end
  always @(negedge clk_o) begin
    if (rst_n && t_r > 0.0 && ($realtime - t_r) < MIN_HALF - 0.1) runts++;
    t_f = $realtime;
  end

  function automatic real exp_period(input int idx);
    case (idx)
      0: return 7.0;
      1: return 61.0;
      2: return 13.0;
      3: return 17.0;
      default: return 23.0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write(input logic [CFG_W-1:0] d, input logic [CFG_W-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!rd_data[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic check_period(input string req, input int idx);
    realtime t1;
    real p, e;
    repeat (2) @(posedge clk_o);
    t1 = $realtime;
    @(posedge clk_o);
    p = $realtime - t1;
    e = exp_period(idx);
    check(p > e - 0.05 && p < e + 0.05, req, "output period ps", longint'(p * 1000.0), longint'(e * 1000.0));
    @(negedge clk);
  endtask

  task automatic check_word(input string req, input bit exp_busy);
    check(rd_data[2:0] == 3'(cur), req, "select field", rd_data[2:0], cur);
    check(rd_data[3] == exp_busy && busy == exp_busy, req, "busy", rd_data[3], exp_busy);
    check(rd_data[CFG_W-1:4] == exp_up, req, "upper field", rd_data[CFG_W-1:4], exp_up);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: start-up handover to source 0
    check(rd_data[3] == 1'b1, "R5", "busy after reset", rd_data[3], 1);
    wait_idle();
    check_word("R5", 1'b0);
    check_period("R1", 0);

    // R6: same index
    write(32'h0, 32'h7);
    check_word("R6", 1'b0);

    // R4: bit 3 written with 1, select unchanged
    write(32'h8, 32'hF);
    check_word("R4", 1'b0);

    // R8: masked upper write, select untouched
    write(32'h5A5A_0003, 32'hFFFF_0000);
    exp_up[31:16] = 16'h5A5A;
    check_word("R8", 1'b0);

    // R3: invalid index
    write(32'h6, 32'h7);
    check_word("R3", 1'b0);
    check_period("R3", 0);

    // R4/R5: switch to slow source
    write(32'h1, 32'h7);
    cur = 1;
    check_word("R4", 1'b1);
    wait_idle();
    check_word("R5", 1'b0);
    check_period("R1", 1);

    // R7: second write while busy
    write(32'h2, 32'h7);
    write(32'h4, 32'h7);
    cur = 4;
    check_word("R7", 1'b1);
    check_word("R2", 1'b1);
    wait_idle();
    check_word("R7", 1'b0);
    check_period("R7", 4);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int idx;
      logic [31:0] up;
      bit sw;
      idx = int'($urandom % 8);
      up = $urandom;
      write({up[31:4], up[3], 3'(idx)}, 32'hFFFF_FFFF);
      exp_up = up[31:4];
      sw = (idx < 5) && (idx != cur);
      if (sw) cur = idx;
      check_word(idx >= 5 ? "R3" : (sw ? "R4" : "R6"), sw);
      wait_idle();
      check_word("R2", 1'b0);
      if (sw) check_period("R1", cur);
    end

    check(runts == 0, "R9", "runt pulses", runts, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule